// File: doc/BRIEF.md
# Prescaled Watchdog Timer

A watchdog peripheral on a minimal register bus (address, write strobe, write data, combinational read data) with three word-aligned 32-bit registers: a control register, a reload register and a live count register. The system clock is divided in two stages: an 8-bit programmable prescaler divides by its value plus one, and a selectable fixed stage divides by 16, 32, 64 or 128. Each output pulse of this chain is one count tick for a 16-bit down-counter.

When the counter is already at zero and a tick arrives, the block reloads the counter from the reload register and expires. On expiry it can raise a one-cycle interrupt pulse, a fixed-length system reset pulse, or both, each under its own control bit. Software keeps the system alive by writing the count register before it runs out. Clearing the run bit freezes the counter and clears both divider stages, so counting resumes one full division period after it is enabled again.

Top module: `tick_watchdog`

## Requirements
- R1: After reset the control register reads 0x0000_8018 (prescaler 0x80, divider select 3, run, interrupt enable and reset enable all 0), the reload and count registers read 0x0000_8000, and both outputs are low.
- R2: Word 0 (byte address 0x0) is control, word 1 (0x4) is reload in bits 15:0, word 2 (0x8) is the count in bits 15:0; in control, bit 0 is reset enable, bit 2 interrupt enable, bits 4:3 divider select, bit 5 run and bits 15:8 the prescaler value. Defined fields read back as written, every other bit and any other address read zero.
- R3: With prescaler value P and select S, ticks occur every (P+1)*2^(4+S) clocks; the first tick after the run bit is set changes the count exactly that many clocks after the enabling write edge.
- R4: While running, each tick lowers a nonzero count by one.
- R5: A tick that finds the count at zero loads the count from the reload register and counts as an expiry.
- R6: With interrupt enable set, each expiry drives irq_o high for exactly one clock, in the cycle right after the reload edge.
- R7: With reset enable set, each expiry drives rst_req_o high for RST_LEN consecutive clocks starting the cycle after the reload edge (default 8).
- R8: Interrupt and reset actions are independent: with only one enable set, the other output never rises.
- R9: A write to the count register loads the counter on that edge, taking priority over a tick, and periodic writes keep the block from expiring.
- R10: Clearing the run bit stops counting; the count and reload values hold and no expiry occurs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| addr_i | input | ADDR_W | Byte address of the register access |
| we_i | input | 1 | Write strobe |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for addr_i, combinational |
| irq_o | output | 1 | One-cycle interrupt pulse on expiry |
| rst_req_o | output | 1 | System reset request pulse on expiry |

## Verification
A divider stage that keeps stale phase across a stop, or compares against the wrong limit, shows up on the very first count change after enabling, which arrives early or late by a measurable number of clocks; sweeping every select value with small prescaler values pins this to the exact cycle. A counter or expiry fault shows at the count register within one tick and at irq_o or rst_req_o in the cycle after the reload edge, so the pulse counts over a fixed window expose a wrong width, a missing enable gate or a leak between the two actions.

// File: rtl/twd_pkg.sv
package twd_pkg;
  parameter int unsigned PRE_W   = 8;
  parameter int unsigned SEL_W   = 2;
  parameter int unsigned CNT_W   = 16;
  parameter int unsigned BASE_SH = 4;

  parameter int unsigned CTRL_WORD   = 0;
  parameter int unsigned RELOAD_WORD = 1;
  parameter int unsigned COUNT_WORD  = 2;

  parameter int unsigned BIT_RSTEN = 0;
  parameter int unsigned BIT_IRQEN = 2;
  parameter int unsigned SEL_LO    = 3;
  parameter int unsigned BIT_RUN   = 5;
  parameter int unsigned PRE_LO    = 8;

  parameter logic [CNT_W-1:0] CNT_RST = 16'h8000;
  parameter logic [PRE_W-1:0] PRE_RST = 8'h80;
  parameter logic [SEL_W-1:0] SEL_RST = 2'd3;

  typedef struct packed {
    logic [PRE_W-1:0] presc;
    logic [SEL_W-1:0] dsel;
    logic             run;
    logic             irq_en;
    logic             rst_en;
  } ctrl_t;
endpackage

// File: rtl/twd_prescale.sv
module twd_prescale
  import twd_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic [PRE_W-1:0] div_i,
  output logic             stb_o
);
  logic [PRE_W-1:0] pre_q;
  logic             wrap;

  assign wrap  = pre_q >= div_i;
  assign stb_o = run_i & wrap;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     pre_q <= '0;
    else if (!run_i) pre_q <= '0;
    else if (wrap)   pre_q <= '0;
    else             pre_q <= pre_q + 1'b1;
  end

  // R3
  pre_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> pre_q == '0) else $error("prescaler not cleared while stopped");
endmodule

// File: rtl/twd_postdiv.sv
module twd_postdiv
  import twd_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             stb_i,
  input  logic [SEL_W-1:0] sel_i,
  output logic             tick_o
);
  localparam int unsigned DIV_W = BASE_SH + (1 << SEL_W) - 1;

  logic [DIV_W:0]   span;
  logic [DIV_W-1:0] lim;
  logic [DIV_W-1:0] div_q;
  logic             wrap;

  assign span   = (DIV_W+1)'(1) << (BASE_SH + 32'(sel_i));
  assign lim    = DIV_W'(span - 1'b1);
  assign wrap   = div_q >= lim;
  assign tick_o = stb_i & wrap;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     div_q <= '0;
    else if (!run_i) div_q <= '0;
    else if (stb_i)  div_q <= wrap ? '0 : div_q + 1'b1;
  end

  // R3
  div_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && !stb_i) |=> div_q == $past(div_q)) else $error("divider moved without strobe");
endmodule

// File: rtl/twd_count.sv
module twd_count
  import twd_pkg::*;
#(
  parameter int unsigned RST_LEN = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             tick_i,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  input  logic [CNT_W-1:0] reload_i,
  input  logic             irq_en_i,
  input  logic             rst_en_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             irq_o,
  output logic             rst_o
);
  localparam int unsigned RC_W = $clog2(RST_LEN + 1);

  logic [CNT_W-1:0] cnt_q;
  logic [RC_W-1:0]  rc_q;
  logic             irq_q;
  logic             at_zero;
  logic             expire;

  assign at_zero = cnt_q == '0;
  assign expire  = tick_i & at_zero & ~load_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= CNT_RST;
    else if (load_i) cnt_q <= load_val_i;
    else if (tick_i) cnt_q <= at_zero ? reload_i : cnt_q - 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      irq_q <= 1'b0;
      rc_q  <= '0;
    end else begin
      irq_q <= expire & irq_en_i;
      if (expire && rst_en_i) rc_q <= RC_W'(RST_LEN);
      else if (rc_q != '0)    rc_q <= rc_q - 1'b1;
    end
  end

  assign cnt_o = cnt_q;
  assign irq_o = irq_q;
  assign rst_o = rc_q != '0;

  // R4
  dec_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && !load_i && !at_zero) |=> cnt_q == CNT_W'($past(cnt_q) - 1'b1))
    else $error("count did not decrement");
  // R5
  reload_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && !load_i && at_zero) |=> cnt_q == $past(reload_i))
    else $error("count did not reload");
  // R9
  load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> cnt_q == $past(load_val_i)) else $error("service write lost");
  // R6
  irq_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_q |=> !irq_q) else $error("interrupt wider than one cycle");
  // R7
  rst_len_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (expire && rst_en_i) |=> (rst_o && rc_q <= RC_W'(RST_LEN))) else $error("reset pulse missing");
  // R10
  hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run_i && !load_i) |=> $stable(cnt_q)) else $error("count moved while stopped");
endmodule

// File: rtl/tick_watchdog.sv
module tick_watchdog
  import twd_pkg::*;
#(
  parameter int unsigned ADDR_W  = 4,
  parameter int unsigned RST_LEN = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              we_i,
  input  logic [31:0]       wdata_i,
  output logic [31:0]       rdata_o,
  output logic              irq_o,
  output logic              rst_req_o
);
  localparam int unsigned WIDX_W = ADDR_W - 2;

  ctrl_t             ctrl_q;
  logic [CNT_W-1:0]  reload_q;
  logic [CNT_W-1:0]  cnt;
  logic [WIDX_W-1:0] widx;
  logic              aligned;
  logic              hit_ctrl, hit_reload, hit_count;
  logic              pre_stb, tick;
  logic              unused_bits;

  assign widx       = addr_i[ADDR_W-1:2];
  assign aligned    = addr_i[1:0] == 2'b00;
  assign hit_ctrl   = aligned && widx == WIDX_W'(CTRL_WORD);
  assign hit_reload = aligned && widx == WIDX_W'(RELOAD_WORD);
  assign hit_count  = aligned && widx == WIDX_W'(COUNT_WORD);
  assign unused_bits = ^{wdata_i[31:PRE_LO+PRE_W], wdata_i[7:6], wdata_i[1]};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q   <= '{presc: PRE_RST, dsel: SEL_RST, run: 1'b0, irq_en: 1'b0, rst_en: 1'b0};
      reload_q <= CNT_RST;
    end else if (we_i) begin
      if (hit_ctrl) begin
        ctrl_q.presc  <= wdata_i[PRE_LO +: PRE_W];
        ctrl_q.dsel   <= wdata_i[SEL_LO +: SEL_W];
        ctrl_q.run    <= wdata_i[BIT_RUN];
        ctrl_q.irq_en <= wdata_i[BIT_IRQEN];
        ctrl_q.rst_en <= wdata_i[BIT_RSTEN];
      end
      if (hit_reload) reload_q <= wdata_i[CNT_W-1:0];
    end
  end

  always_comb begin
    rdata_o = '0;
    if (hit_ctrl) begin
      rdata_o[PRE_LO +: PRE_W] = ctrl_q.presc;
      rdata_o[SEL_LO +: SEL_W] = ctrl_q.dsel;
      rdata_o[BIT_RUN]         = ctrl_q.run;
      rdata_o[BIT_IRQEN]       = ctrl_q.irq_en;
      rdata_o[BIT_RSTEN]       = ctrl_q.rst_en;
    end else if (hit_reload) begin
      rdata_o[CNT_W-1:0] = reload_q;
    end else if (hit_count) begin
      rdata_o[CNT_W-1:0] = cnt;
    end
  end

  twd_prescale i_prescale (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (ctrl_q.run),
    .div_i  (ctrl_q.presc),
    .stb_o  (pre_stb)
  );

  twd_postdiv i_postdiv (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (ctrl_q.run),
    .stb_i  (pre_stb),
    .sel_i  (ctrl_q.dsel),
    .tick_o (tick)
  );

  twd_count #(.RST_LEN(RST_LEN)) i_count (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .run_i      (ctrl_q.run),
    .tick_i     (tick),
    .load_i     (we_i & hit_count),
    .load_val_i (wdata_i[CNT_W-1:0]),
    .reload_i   (reload_q),
    .irq_en_i   (ctrl_q.irq_en),
    .rst_en_i   (ctrl_q.rst_en),
    .cnt_o      (cnt),
    .irq_o      (irq_o),
    .rst_o      (rst_req_o)
  );

  // R1
  out_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ctrl_q.irq_en && !$past(ctrl_q.irq_en)) |=> !irq_o) else $error("interrupt while disabled");
endmodule

// File: tb/test_tick_watchdog.sv
module test_tick_watchdog;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [3:0]  addr_i = '0;
  logic        we_i = 1'b0;
  logic [31:0] wdata_i = '0;
  logic [31:0] rdata_o;
  logic        irq_o, rst_req_o;

  int checks = 0;
  int errors = 0;
  int irq_hits = 0;
  int rst_hits = 0;
  bit done = 1'b0;

  localparam int RST_LEN = 8;

  always #4 clk_i = ~clk_i;

  tick_watchdog #(.ADDR_W(4), .RST_LEN(RST_LEN)) i_tick_watchdog (
    .clk_i(clk_i), .rst_ni(rst_ni), .addr_i(addr_i), .we_i(we_i),
    .wdata_i(wdata_i), .rdata_o(rdata_o), .irq_o(irq_o), .rst_req_o(rst_req_o)
  );

  always @(negedge clk_i) begin
    if (irq_o) irq_hits++;
    if (rst_req_o) rst_hits++;
  end

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [3:0] a, logic [31:0] d);
    @(negedge clk_i);
    addr_i = a; wdata_i = d; we_i = 1'b1;
    @(posedge clk_i);
    @(negedge clk_i);
    we_i = 1'b0;
  endtask

  task automatic rd(logic [3:0] a, output logic [31:0] d);
    @(negedge clk_i);
    addr_i = a;
    #1 d = rdata_o;
  endtask

  // clocks until the count register differs from 'from'
  task automatic wait_change(logic [31:0] from, output int k);
    addr_i = 4'h8;
    k = 0;
    for (int i = 0; i < 3000; i++) begin
      @(posedge clk_i);
      k++;
      @(negedge clk_i);
      #1;
      if (rdata_o !== from) break;
    end
  endtask

  initial begin
    logic [31:0] v, v2;
    int k, ib, rb;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;

    // R1 reset state
    rd(4'h0, v); chk("R1 ctrl", v, 32'h0000_8018);
    rd(4'h4, v); chk("R1 reload", v, 32'h0000_8000);
    rd(4'h8, v); chk("R1 count", v, 32'h0000_8000);
    chk("R1 outputs", {30'd0, irq_o, rst_req_o}, 32'd0);

    // R2 readback and map
    wr(4'h0, 32'hFFFF_FFFF);
    rd(4'h0, v); chk("R2 ctrl fields", v, 32'h0000_FF3D);
    wr(4'h0, 32'h0);
    rd(4'h0, v); chk("R2 ctrl clear", v, 32'h0);
    wr(4'h4, 32'h1234_ABCD);
    rd(4'h4, v); chk("R2 reload", v, 32'h0000_ABCD);
    rd(4'hC, v); chk("R2 unmapped", v, 32'h0);
    rd(4'h2, v); chk("R2 unaligned", v, 32'h0);

    // R3/R4 sweep of prescaler and select
    for (int p = 0; p < 4; p++) begin
      for (int s = 0; s < 4; s++) begin
        wr(4'h0, 32'h0);
        wr(4'h8, 32'd5);
        wr(4'h0, (p << 8) | (s << 3) | 32'h20);
        wait_change(32'd5, k);
        chk($sformatf("R3 first tick p=%0d s=%0d", p, s), k, (p + 1) * (16 << s));
        chk("R4 dec", rdata_o, 32'd4);
        wait_change(32'd4, k);
        chk($sformatf("R3 period p=%0d s=%0d", p, s), k, (p + 1) * (16 << s));
        chk("R4 dec2", rdata_o, 32'd3);
        // partial progress before the next stop leaves stale phase if not cleared
        repeat (7) @(posedge clk_i);
      end
    end

    // R5/R6/R7 expiry with both actions
    wr(4'h0, 32'h0);
    wr(4'h4, 32'd2);
    wr(4'h8, 32'd1);
    ib = irq_hits; rb = rst_hits;
    wr(4'h0, 32'h25);
    addr_i = 4'h8;
    for (int c = 1; c <= 33; c++) begin
      @(posedge clk_i); @(negedge clk_i); #1;
      if (c == 16) chk("R4 to zero", rdata_o, 32'd0);
      if (c == 31) begin
        chk("R5 still zero", rdata_o, 32'd0);
        chk("R6 no early irq", {31'd0, irq_o}, 32'd0);
      end
      if (c == 32) begin
        chk("R5 reload", rdata_o, 32'd2);
        chk("R6 irq pulse", {31'd0, irq_o}, 32'd1);
        chk("R7 reset start", {31'd0, rst_req_o}, 32'd1);
      end
      if (c == 33) chk("R6 irq one cycle", {31'd0, irq_o}, 32'd0);
    end
    wr(4'h0, 32'h0);
    repeat (12) @(posedge clk_i);
    @(negedge clk_i); #1;
    chk("R6 irq count", irq_hits - ib, 1);
    chk("R7 reset width", rst_hits - rb, RST_LEN);

    // R8 interrupt only, reload 0 expires on every tick
    wr(4'h4, 32'd0);
    wr(4'h8, 32'd0);
    #1 ib = irq_hits; rb = rst_hits;
    wr(4'h0, 32'h24);
    #1 ib = irq_hits; rb = rst_hits;
    repeat (100) @(posedge clk_i);
    @(negedge clk_i); #1;
    chk("R8 irq-only irqs", irq_hits - ib, 6);
    chk("R8 irq-only no reset", rst_hits - rb, 0);
    wr(4'h0, 32'h0);
    wr(4'h8, 32'd0);
    repeat (10) @(posedge clk_i);

    // R8 reset only
    wr(4'h0, 32'h21);
    #1 ib = irq_hits; rb = rst_hits;
    repeat (100) @(posedge clk_i);
    @(negedge clk_i); #1;
    chk("R8 reset-only no irq", irq_hits - ib, 0);
    chk("R8 reset-only reset cycles", rst_hits - rb, 45);
    wr(4'h0, 32'h0);
    repeat (12) @(posedge clk_i);

    // R9 service keeps it alive
    wr(4'h4, 32'd2);
    wr(4'h8, 32'd3);
    wr(4'h0, 32'h25);
    #1 ib = irq_hits; rb = rst_hits;
    for (int n = 0; n < 10; n++) begin
      repeat (38) @(posedge clk_i);
      wr(4'h8, 32'd3);
      #1;
      chk("R9 load visible", rdata_o, 32'd3);
    end
    chk("R9 no expiry irq", irq_hits - ib, 0);
    chk("R9 no expiry reset", rst_hits - rb, 0);

    // R10 stop holds state
    repeat (20) @(posedge clk_i);
    wr(4'h0, 32'h0);
    rd(4'h8, v);
    #1 ib = irq_hits; rb = rst_hits;
    repeat (300) @(posedge clk_i);
    rd(4'h8, v2); chk("R10 count held", v2, v);
    rd(4'h4, v2); chk("R10 reload held", v2, 32'd2);
    chk("R10 no expiry", (irq_hits - ib) + (rst_hits - rb), 0);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(8 * 150000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog act=hung exp=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule